// File: doc/BRIEF.md
# Vector Arithmetic Right Shifter with Wide Shift Counts

This block takes a vector operand of fixed width and shifts every narrow element in it right arithmetically. Each element is 8, 16 or 32 bits wide, as the size code selects. The shift count for an element is not stored next to it. It comes from the 64-bit lane of a second vector that covers the same bit positions. As a result, every element inside one 64-bit lane uses the same count. All 64 bits of the count matter. A count equal to or larger than the element width fills the element with copies of its sign bit.

One operation is accepted per cycle when `valid_i` is high. The result appears one cycle later on registered outputs, and the block never stalls. Size code 3 is reserved: it reports an illegal encoding, produces no valid result and gives a zero result vector. The vector length is a parameter and must be a multiple of 64. Every element of the result is written; there is no masking.

Top module: `vwsra_top`

## Requirements
- R1: With size code 0, each 8-bit element k (bits 8k+7..8k) of the result is element k of `opa_i` shifted right arithmetically by the effective count.
- R2: With size code 1, each 16-bit element is shifted the same way.
- R3: With size code 2, each 32-bit element is shifted the same way.
- R4: Element k of width W takes its count from bits 64j+63..64j of `opb_i`, where j = (k·W)/64. All elements inside one 64-bit lane share that lane's count.
- R5: The count is an unsigned 64-bit value that is never reduced modulo W. Any count ≥ W, including a count whose only set bits are above bit 31, makes the element all copies of its sign bit.
- R6: The bits vacated by the shift take the element's original sign bit. A count of 0 leaves the element unchanged. A count of W−1 gives all ones for a negative element and zero for a non-negative one.
- R7: `valid_o` is high in the cycle after a cycle with `valid_i` high and a size code of 0, 1 or 2. Otherwise it is low.
- R8: Size code 3 with `valid_i` high sets `illegal_o` in the next cycle, keeps `valid_o` low in that cycle and gives a zero result vector.
- R9: While `rst_ni` is low, `valid_o`, `illegal_o` and `result_o` are all zero.
- R10: In a cycle where `valid_i` is low, the value of `result_o` in the next cycle is unchanged, whatever the operands and size code are.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| valid_i | input | 1 | Operation request this cycle |
| size_i | input | 2 | Element size code: 0 = 8-bit, 1 = 16-bit, 2 = 32-bit, 3 = reserved |
| opa_i | input | VL | Vector of elements to shift |
| opb_i | input | VL | Vector of 64-bit shift counts |
| valid_o | output | 1 | Result valid, one cycle after the request |
| illegal_o | output | 1 | Reserved size code was requested in the previous cycle |
| result_o | output | VL | Shifted vector; zero after an illegal request |

## Verification
The hardest case to reach is a count that is large but has a low part that looks like a small shift. For example, 2^32 or 2^32+2 would act as a shift of 0 or 2 if the upper bits were dropped or the count were taken modulo W. The stimulus therefore loads lanes with counts whose upper 32 bits are set and whose lower bits are small or zero, next to lanes holding 0, W−1 and exactly W. It does this for each element size, with elements of both signs in every lane. This also shows that lanes do not borrow counts from their neighbours.

// File: rtl/vwsra_pkg.sv
package vwsra_pkg;
  typedef enum logic [1:0] {
    SZ_B8   = 2'd0,
    SZ_H16  = 2'd1,
    SZ_W32  = 2'd2,
    SZ_RSV  = 2'd3
  } size_e;

  localparam int unsigned LANE_W  = 64;
  localparam int unsigned N_SIZES = 3;

  function automatic int unsigned size_width(int unsigned code);
    return 8 << code;
  endfunction
endpackage

// File: rtl/vwsra_cnt_sat.sv
// Clamps a 64-bit count to 0..W, W a power of two.
module vwsra_cnt_sat #(
  parameter int unsigned W  = 8,
  localparam int unsigned LW = $clog2(W),
  localparam int unsigned AW = LW + 1
) (
  input  logic [63:0]   cnt_i,
  output logic [AW-1:0] amt_o
);
  logic ge_w;

  assign ge_w  = |cnt_i[63:LW];
  assign amt_o = ge_w ? AW'(W) : {1'b0, cnt_i[LW-1:0]};
endmodule

// File: rtl/vwsra_elem.sv
module vwsra_elem #(
  parameter int unsigned W  = 8,
  localparam int unsigned AW = $clog2(W) + 1
) (
  input  logic [W-1:0]  d_i,
  input  logic [AW-1:0] amt_i,
  output logic [W-1:0]  q_o
);
  logic sgn;

  assign sgn = d_i[W-1];
  assign q_o = (amt_i >= AW'(W)) ? {W{sgn}} : W'($signed(d_i) >>> amt_i);

  always_comb begin
    AST_SIGN_KEEP: assert (q_o[W-1] == d_i[W-1]); // R6
  end
endmodule

// File: rtl/vwsra_lane.sv
// One 64-bit lane: every element in it uses the lane's own count.
module vwsra_lane
  import vwsra_pkg::*;
(
  input  logic [LANE_W-1:0] data_i,
  input  logic [LANE_W-1:0] cnt_i,
  input  size_e             size_i,
  output logic [LANE_W-1:0] res_o
);
  logic [LANE_W-1:0] res_by [N_SIZES];

  for (genvar g = 0; g < N_SIZES; g++) begin : g_size
    localparam int unsigned W  = 8 << g;
    localparam int unsigned NE = LANE_W / W;
    localparam int unsigned AW = $clog2(W) + 1;

    logic [AW-1:0] amt;

    vwsra_cnt_sat #(.W(W)) u_sat (
      .cnt_i (cnt_i),
      .amt_o (amt)
    );

    for (genvar j = 0; j < NE; j++) begin : g_elem
      vwsra_elem #(.W(W)) u_elem (
        .d_i   (data_i[j*W +: W]),
        .amt_i (amt),
        .q_o   (res_by[g][j*W +: W])
      );
    end
  end

  always_comb begin
    unique case (size_i)
      SZ_B8:   res_o = res_by[0];
      SZ_H16:  res_o = res_by[1];
      SZ_W32:  res_o = res_by[2];
      default: res_o = '0;
    endcase
  end
endmodule

// File: rtl/vwsra_top.sv
module vwsra_top
  import vwsra_pkg::*;
#(
  parameter int unsigned VL = 256,
  localparam int unsigned N_LANES = VL / LANE_W
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          valid_i,
  input  logic [1:0]    size_i,
  input  logic [VL-1:0] opa_i,
  input  logic [VL-1:0] opb_i,
  output logic          valid_o,
  output logic          illegal_o,
  output logic [VL-1:0] result_o
);
  size_e         size_q;
  logic          legal;
  logic [VL-1:0] res_d;

  initial begin
    AST_VL_MULT64: assert (VL % LANE_W == 0 && VL >= LANE_W);
  end

  assign size_q = size_e'(size_i);
  assign legal  = (size_q != SZ_RSV);

  for (genvar l = 0; l < N_LANES; l++) begin : g_lane
    vwsra_lane u_lane (
      .data_i (opa_i[l*LANE_W +: LANE_W]),
      .cnt_i  (opb_i[l*LANE_W +: LANE_W]),
      .size_i (size_q),
      .res_o  (res_d[l*LANE_W +: LANE_W])
    );
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      valid_o   <= 1'b0;
      illegal_o <= 1'b0;
      result_o  <= '0;
    end else begin
      valid_o   <= valid_i && legal;
      illegal_o <= valid_i && !legal;
      if (valid_i) result_o <= legal ? res_d : '0;
    end
  end

  AST_VALID_LAT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_i && size_i != 2'd3) |=> (valid_o && !illegal_o)); // R7
  AST_IDLE_QUIET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !valid_i |=> (!valid_o && !illegal_o)); // R7
  AST_ILLEGAL_LAT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_i && size_i == 2'd3) |=> (illegal_o && !valid_o)); // R8
  AST_ILLEGAL_ZERO: assert property (@(posedge clk_i) disable iff (!rst_ni)
    illegal_o |-> (result_o == '0)); // R8
  AST_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !valid_i |=> $stable(result_o)); // R10
endmodule

// File: tb/vwsra_top_test.sv
module vwsra_top_test;
  localparam int unsigned VL = 256;

  logic          clk = 1'b0;
  logic          rst_ni = 1'b0;
  logic          valid_i = 1'b0;
  logic [1:0]    size_i = 2'd0;
  logic [VL-1:0] opa_i = '0;
  logic [VL-1:0] opb_i = '0;
  logic          valid_o;
  logic          illegal_o;
  logic [VL-1:0] result_o;

  int total = 0;
  int bad = 0;
  logic [63:0] seed = 64'h9E3779B97F4A7C15;

  always #2 clk = ~clk;

  vwsra_top #(.VL(VL)) uut (
    .clk_i     (clk),
    .rst_ni    (rst_ni),
    .valid_i   (valid_i),
    .size_i    (size_i),
    .opa_i     (opa_i),
    .opb_i     (opb_i),
    .valid_o   (valid_o),
    .illegal_o (illegal_o),
    .result_o  (result_o)
  );

  function automatic logic [VL-1:0] ref_sra(logic [VL-1:0] a, logic [VL-1:0] b, logic [1:0] sz);
    int w;
    int n;
    logic [VL-1:0] r;
    w = 8 << sz;
    n = VL / w;
    r = '0;
    for (int e = 0; e < n; e++) begin
      logic [63:0] raw;
      logic [63:0] cnt;
      logic [63:0] val;
      longint sv;
      int sh;
      raw = 64'(a >> (e * w));
      cnt = 64'(b >> (((e * w) / 64) * 64));
      sv  = $signed(raw << (64 - w)) >>> (64 - w);
      sh  = (cnt >= 64'(w)) ? w : int'(cnt[5:0]);
      sv  = sv >>> sh;
      val = 64'(sv) & ((64'd1 << w) - 64'd1);
      r   = r | (VL'(val) << (e * w));
    end
    return r;
  endfunction

  function automatic logic [63:0] next_rand();
    seed = seed ^ (seed << 13);
    seed = seed ^ (seed >> 7);
    seed = seed ^ (seed << 17);
    return seed;
  endfunction

  task automatic chk(input string req, input logic [VL-1:0] act, input logic [VL-1:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // drive one request, sample the registered outputs after the next edge
  task automatic issue(input logic [1:0] sz, input logic [VL-1:0] a, input logic [VL-1:0] b);
    @(negedge clk);
    valid_i = 1'b1;
    size_i  = sz;
    opa_i   = a;
    opb_i   = b;
    @(negedge clk);
    valid_i = 1'b0;
  endtask

  task automatic run_op(input string req, input logic [1:0] sz, input logic [VL-1:0] a, input logic [VL-1:0] b);
    issue(sz, a, b);
    chk(req, result_o, ref_sra(a, b, sz));
    chk("R7", VL'(valid_o), VL'(1'b1));
  endtask

  task automatic t_reset();
    chk("R9", VL'(valid_o), '0);
    chk("R9", VL'(illegal_o), '0);
    chk("R9", result_o, '0);
  endtask

  localparam logic [VL-1:0] DATA_A = {64'h807FFF01C33C55AA, 64'h0123456789ABCDEF,
                                      64'hFEDCBA9876543210, 64'h8000000180007FFF};

  task automatic t_bytes();
    run_op("R1", 2'd0, DATA_A, {64'h0000000100000000, 64'd8, 64'd7, 64'd0});
    run_op("R1", 2'd0, ~DATA_A, {64'd3, 64'd1, 64'd6, 64'd2});
  endtask

  task automatic t_halves();
    run_op("R2", 2'd1, DATA_A, {64'hFFFFFFFF00000003, 64'd16, 64'd15, 64'd1});
    run_op("R2", 2'd1, ~DATA_A, {64'd0, 64'd9, 64'd4, 64'd12});
  endtask

  task automatic t_words();
    run_op("R3", 2'd2, DATA_A, {64'h8000000000000000, 64'd32, 64'd31, 64'd5});
    run_op("R3", 2'd2, ~DATA_A, {64'd17, 64'd0, 64'd28, 64'd1});
  endtask

  // distinct counts per lane, negative data everywhere
  task automatic t_lane_share();
    logic [VL-1:0] a;
    logic [VL-1:0] exp;
    a = {32{8'h80}};
    issue(2'd0, a, {64'd7, 64'd3, 64'd1, 64'd0});
    exp = {{8{8'hFF}}, {8{8'hF0}}, {8{8'hC0}}, {8{8'h80}}};
    chk("R4", result_o, exp);
  endtask

  task automatic t_no_modulo();
    logic [VL-1:0] a;
    a = {4{64'h7FFF_FFFF_8000_0000}};
    issue(2'd2, a, {4{64'h0000000100000002}});
    chk("R5", result_o, {4{64'h0000_0000_FFFF_FFFF}});
    issue(2'd0, DATA_A, {4{64'h0000000100000002}});
    chk("R5", result_o, ref_sra(DATA_A, {4{64'h0000000100000002}}, 2'd0));
    issue(2'd1, {16{16'h8001}}, {4{64'h0000_0000_0000_0010}});
    chk("R5", result_o, {16{16'hFFFF}});
  endtask

  task automatic t_sign_fill();
    issue(2'd1, {8{16'h8000, 16'h7FFF}}, {4{64'd0}});
    chk("R6", result_o, {8{16'h8000, 16'h7FFF}});
    issue(2'd1, {8{16'h8000, 16'h7FFF}}, {4{64'd15}});
    chk("R6", result_o, {8{16'hFFFF, 16'h0000}});
    issue(2'd2, {8{32'hC000_0000}}, {4{64'd4}});
    chk("R6", result_o, {8{32'hFC00_0000}});
  endtask

  task automatic t_illegal();
    issue(2'd3, DATA_A, {4{64'd1}});
    chk("R8", VL'(illegal_o), VL'(1'b1));
    chk("R8", VL'(valid_o), '0);
    chk("R8", result_o, '0);
    @(negedge clk);
    chk("R7", VL'(illegal_o), '0);
  endtask

  task automatic t_hold();
    logic [VL-1:0] held;
    issue(2'd0, DATA_A, {64'd1, 64'd2, 64'd3, 64'd4});
    held = result_o;
    for (int i = 0; i < 3; i++) begin
      size_i = 2'(i);
      opa_i  = ~DATA_A;
      opb_i  = {4{64'(i)}};
      @(negedge clk);
      chk("R10", result_o, held);
      chk("R7", VL'(valid_o), '0);
    end
  endtask

  task automatic t_sweep();
    for (int i = 0; i < 24; i++) begin
      logic [VL-1:0] a;
      logic [VL-1:0] b;
      logic [1:0] sz;
      for (int l = 0; l < 4; l++) begin
        logic [63:0] r;
        a[l*64 +: 64] = next_rand();
        r = next_rand();
        b[l*64 +: 64] = r[2] ? r : 64'(r[63:58] % 6'd40);
      end
      sz = 2'(i % 3);
      run_op(sz == 2'd0 ? "R1" : (sz == 2'd1 ? "R2" : "R3"), sz, a, b);
    end
  endtask

  initial begin
    #(200000 * 4);
    bad++;
    total++;
    $display("FAIL watchdog actual=running expected=finished");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    rst_ni = 1'b1;
    t_bytes();
    t_halves();
    t_words();
    t_lane_share();
    t_no_modulo();
    t_sign_fill();
    t_illegal();
    t_hold();
    t_sweep();
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule